// File: doc/BRIEF.md
# Latched Interrupt Priority Encoder

This block gathers a set of active-high interrupt request lines from peripherals and turns them into the two signals a processor with level-coded interrupts expects. One is an active-low master request, asserted whenever any line is pending. The other is a 4-bit level code that holds the number of the most urgent pending line. Line 1 is the most urgent and line 15 the least urgent.

Both outputs are registered on the same clock edge, so the processor never sees a code that disagrees with the master request. The code is captured when the master request first goes active. It changes only when a more urgent line arrives or when the current winner releases its line. While no line is pending, the code is held at zero.

A peripheral keeps its line high until it has received its own acknowledge. The block only encodes the lines; it makes no acknowledges.

Top module: `irq_level_encoder`

## Requirements
- R1: While `rst` is high and on the first output cycle after it, `irq_n` is 1 and `level` is 0.
- R2: If any bit of `req` is 1 at a rising clock edge, `irq_n` is 0 after that edge.
- R3: Bit k-1 of `req` carries request line k (k = 1..15). After an edge at which any line is high, `level` equals the smallest such k, written as an unsigned binary number.
- R4: After an edge at which every bit of `req` is 0, `irq_n` is 1 and `level` is 0.
- R5: A request on a line with a larger number than the latched `level` leaves `level` unchanged while the latched line stays high.
- R6: A request on a line with a smaller number than the latched `level` replaces `level` with that line's number one clock later.
- R7: When the latched line drops while other lines remain high, `level` moves to the smallest remaining line number one clock later.
- R8: `irq_n` is 0 exactly when `level` is non-zero.
- R9: While `req` holds steady, both outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 15 | Request lines; bit k-1 carries line k, active high |
| irq_n | output | 1 | Master request, active low |
| level | output | 4 | Number of the most urgent pending line, 0 when idle |

## Verification
The assertions check several rules on every cycle. They check that `irq_n` and `level` always agree, and that any pending line pulls `irq_n` low on the next edge. They check that an idle cycle clears the code, that steady inputs give steady outputs, and that the combinational grant is one-hot and is the lowest-numbered pending line. The bench scenarios cover the rest. Each of the fifteen lines is asserted alone to confirm its code value. A less urgent line is added under a latched code, a more urgent line pre-empts it, and the winner releases its line while others still wait. Long random sequences of sparse and dense request patterns are compared against a reference priority function.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    localparam int unsigned NUM_LINES = 15;
    localparam int unsigned LVL_W     = $clog2(NUM_LINES + 1);

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0]     level_t;

    typedef struct packed {
        logic   active;
        level_t level;
    } enc_out_t;

    // Converts a one-hot grant (bit k-1 = line k) into the line number.
    function automatic level_t grant_to_level(line_vec_t g);
        level_t acc;
        acc = '0;
        for (int unsigned k = 0; k < NUM_LINES; k++) begin
            if (g[k]) acc = acc | level_t'(k + 1);
        end
        return acc;
    endfunction

endpackage

// File: rtl/irq_prio_grant.sv
module irq_prio_grant
    import irq_enc_pkg::*;
#(
    parameter int unsigned LINES = NUM_LINES
) (
    input  logic [LINES-1:0] lines,
    output logic [LINES-1:0] grant,
    output logic             any
);

    logic [LINES:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_chain
            assign grant[i]     = lines[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | lines[i];
        end
    endgenerate

    assign any = blocked[LINES];

    // R3: exactly one grant when something is pending, and no line below it is set.
    always_comb begin
        if (any) begin
            a_grant_onehot_r3: assert ($countones(grant) == 1);
            a_grant_lowest_r3: assert ((lines & (grant - 1'b1)) == '0);
        end else begin
            a_grant_idle_r4: assert (grant == '0);
        end
    end

endmodule

// File: rtl/irq_level_latch.sv
module irq_level_latch
    import irq_enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lines,
    input  line_vec_t grant,
    input  logic      any,
    output enc_out_t  state
);

    enc_out_t nxt;
    logic     held_live;
    logic     win_alive;
    logic     preempt;
    level_t   cand;

    assign cand = grant_to_level(grant);

    // The latched winner is still asserted.
    assign win_alive = state.active && (state.level != '0) && lines[state.level - 1'b1];
    // A more urgent line has arrived.
    assign preempt   = state.active && (cand < state.level);

    always_comb begin
        nxt = state;
        if (!any) begin
            nxt.active = 1'b0;
            nxt.level  = '0;
        end else if (!state.active || !win_alive || preempt) begin
            nxt.active = 1'b1;
            nxt.level  = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= '0;
            held_live <= 1'b0;
        end else begin
            state     <= nxt;
            held_live <= 1'b1;
        end
    end

    p_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (|lines) |=> state.active);

    p_idle_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !(|lines) |=> (!state.active && state.level == '0));

    p_agree_r8: assert property (@(posedge clk) disable iff (rst)
        state.active == (state.level != '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (held_live && $stable(lines)) |=> $stable(state));

    p_preempt_r6: assert property (@(posedge clk) disable iff (rst)
        (state.active && (|(lines & (line_vec_t'(1) << (state.level - 1'b1)) - 1'b1)))
        |=> $past(state.level) > state.level);

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
    import irq_enc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req,
    output logic                 irq_n,
    output logic [LVL_W-1:0]     level
);

    line_vec_t grant;
    logic      any;
    enc_out_t  state;

    irq_prio_grant #(.LINES(NUM_LINES)) u_grant (
        .lines (req),
        .grant (grant),
        .any   (any)
    );

    irq_level_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .lines (req),
        .grant (grant),
        .any   (any),
        .state (state)
    );

    assign irq_n = ~state.active;
    assign level = state.level;

    p_reset_r1: assert property (@(posedge clk) rst |=> (irq_n && level == '0));

endmodule

// File: tb/test_irq_level_encoder.sv
module test_irq_level_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] req = '0;
    logic        irq_n;
    logic [3:0]  level;

    int unsigned n_cmp  = 0;
    int unsigned n_miss = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    irq_level_encoder i_irq_level_encoder (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .irq_n (irq_n),
        .level (level)
    );

    function automatic logic [3:0] ref_level(logic [14:0] r);
        for (int k = 0; k < 15; k++) if (r[k]) return 4'(k + 1);
        return 4'd0;
    endfunction

    task automatic chk(string tag, logic exp_n, logic [3:0] exp_l);
        n_cmp++;
        if (irq_n !== exp_n || level !== exp_l) begin
            n_miss++;
            $display("FAIL %s: irq_n=%b level=%0d expected irq_n=%b level=%0d",
                     tag, irq_n, level, exp_n, exp_l);
        end
    endtask

    // Apply a pattern, let one edge pass, sample at the falling edge.
    task automatic step(logic [14:0] r);
        req = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_chk(string tag, logic [14:0] r);
        step(r);
        chk(tag, (r == 0), ref_level(r));
    endtask

    initial begin
        int unsigned seed;
        logic [14:0] r;
        seed = 32'h1D5E;
        void'($urandom(seed));
        @(negedge clk);
        chk("R1 in reset", 1'b1, 4'd0);
        req = 15'h7FFF;
        repeat (2) @(negedge clk);
        chk("R1 reset with requests", 1'b1, 4'd0);
        req = '0;
        rst = 1'b0;
        step_chk("R1 idle after reset", '0);

        for (int k = 1; k <= 15; k++) begin
            step_chk("R3 single line", 15'(1) << (k - 1));
            step_chk("R4 all dropped", '0);
        end

        step_chk("R2 line 9", 15'(1) << 8);
        step_chk("R5 less urgent line 12 added", (15'(1) << 8) | (15'(1) << 11));
        step_chk("R9 steady", (15'(1) << 8) | (15'(1) << 11));
        step_chk("R6 line 3 pre-empts", (15'(1) << 8) | (15'(1) << 11) | (15'(1) << 2));
        step_chk("R7 winner 3 drops", (15'(1) << 8) | (15'(1) << 11));
        step_chk("R7 winner 9 drops", (15'(1) << 11));
        step_chk("R6 line 1 pre-empts", (15'(1) << 11) | 15'(1));
        step_chk("R5 line 15 added", (15'(1) << 11) | 15'(1) | (15'(1) << 14));
        step_chk("R7 swap to line 12", (15'(1) << 11) | (15'(1) << 14));
        step_chk("R4 all drop", '0);
        step_chk("R3 all lines", 15'h7FFF);
        step_chk("R8 last line only", 15'h4000);

        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) r = 15'($urandom) & 15'($urandom) & 15'($urandom);
            else if (($urandom % 5) == 0) r = '0;
            else if (($urandom % 3) == 0) r = req;
            else r = 15'($urandom);
            step_chk("R3 R8 random", r);
        end

        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog: done=0 expected done=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule